// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits on the write side of a flash-style memory. It examines each bus write and recognises the fixed unlock handshake that precedes every command: two unlock writes, then a command byte. For erase it recognises a second unlock pair followed by the erase selector. Each recognised command is reported as a one-cycle pulse on its own bit of a command vector. An operation controller, which is outside this block, consumes these pulses.

The controller reports its own state back through three inputs: program running, erase running and erase suspended. The decoder uses these inputs to drop commands that have no meaning in the current state. The decoder also holds the read-path selector, which chooses whether reads return array data, identifier data or the status register. For a sector erase it latches the full address of the final write, and the sector number is the top four bits of that address.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `cmd_pulse` is all zero and `read_mode` is 0 (array).
- R2: A write of low byte AAh at command address 5555h, then 55h at 2AAAh, then a code at 5555h produces a single-cycle pulse on one bit of `cmd_pulse`. The pulse appears in the cycle after the clock edge that takes the third write. The code-to-bit map is: F0h→bit0 read array, 90h→bit1 read ID, A0h→bit2 program, B0h→bit5 suspend, D0h→bit6 resume, 70h→bit7 read status, 50h→bit8 clear status, C0h→bit9 sleep, E0h→bit10 abort.
- R3: Code 80h at the third write is followed by AAh@5555h and then 55h@2AAAh. A sixth write of 10h at 5555h pulses bit3 (chip erase). A sixth write of 30h at any address pulses bit4 (sector erase) and loads `erase_addr` with that write's full address, so the sector is `erase_addr[19:16]`.
- R4: Only `wr_addr[14:0]` is compared against the unlock and command addresses. Bits 19:15 have no effect on recognition.
- R5: Any write that departs from the expected address/byte pattern returns the tracker to idle and produces no pulse. The next well-formed sequence is recognised normally.
- R6: An unlisted code at the third write produces no pulse.
- R7: While `busy_pgm` is high and `suspended` is low, only read status (bit7) can pulse.
- R8: While `busy_erase` is high and `suspended` is low (and `busy_pgm` is low), only read status and suspend can pulse.
- R9: While `suspended` is high, regardless of the busy inputs, only read array, read status, abort and resume can pulse. Sleep and all other commands are dropped.
- R10: With no busy or suspended input high, suspend and resume are dropped and every other command is accepted.
- R11: `read_mode` becomes 0 on accepted read array, 1 on accepted read ID, and 2 on accepted read status, program, chip erase or sector erase. All other commands leave it unchanged.
- R12: Cycles with `wr_en` low are not writes: they neither advance the tracker nor cause a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 20 | Write address |
| cmd_byte | input | 8 | Low data byte lane carrying command codes |
| busy_pgm | input | 1 | Program operation running |
| busy_erase | input | 1 | Erase operation running |
| suspended | input | 1 | Erase suspended |
| cmd_pulse | output | 11 | One-hot command pulses (bit map in R2, R3) |
| erase_addr | output | 20 | Address latched with an accepted sector erase |
| read_mode | output | 2 | Read path: 0 array, 1 ID, 2 status |

## Verification
Random three-write and six-write sequences carry random high address bits and random sector addresses, and they run under every combination of operation-state inputs. This separates correct state filtering from plain decoding, and it shows that ignored address bits really are ignored. Sequences broken at each position of the six-write erase, along with unlisted codes, show that the tracker recovers to idle rather than matching late. Sequences driven with the strobe low confirm that only strobed cycles count.

// File: rtl/flash_cmd_pkg.sv
// Shared constants and types for the flash command decoder.
// Assumes command codes are eight bits wide and carried on the low data byte.
package flash_cmd_pkg;
    localparam int NUM_CMDS      = 11;
    localparam int C_RD_ARRAY    = 0;
    localparam int C_RD_ID       = 1;
    localparam int C_PROGRAM     = 2;
    localparam int C_CHIP_ERASE  = 3;
    localparam int C_SECT_ERASE  = 4;
    localparam int C_SUSPEND     = 5;
    localparam int C_RESUME      = 6;
    localparam int C_RD_STATUS   = 7;
    localparam int C_CLR_STATUS  = 8;
    localparam int C_SLEEP       = 9;
    localparam int C_ABORT       = 10;

    typedef logic [NUM_CMDS-1:0] cmd_vec_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_ERS_SETUP,
        SQ_ERS_UNL1,
        SQ_ERS_UNL2
    } seq_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_STATUS = 2'd2
    } rd_mode_e;

    // Maps a third-cycle code to its one-hot command; unlisted codes give zero.
    function automatic cmd_vec_t short_code_hit(input logic [7:0] code);
        cmd_vec_t v;
        v = '0;
        case (code)
            8'hF0: v[C_RD_ARRAY]   = 1'b1;
            8'h90: v[C_RD_ID]      = 1'b1;
            8'hA0: v[C_PROGRAM]    = 1'b1;
            8'hB0: v[C_SUSPEND]    = 1'b1;
            8'hD0: v[C_RESUME]     = 1'b1;
            8'h70: v[C_RD_STATUS]  = 1'b1;
            8'h50: v[C_CLR_STATUS] = 1'b1;
            8'hC0: v[C_SLEEP]      = 1'b1;
            8'hE0: v[C_ABORT]      = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/fcd_seq_tracker.sv
// Tracks progress through the unlock handshake, one step per strobed write.
// Emits a combinational one-hot hit in the cycle of the final write.
// Assumes the command address has already been cut down to its compared bits.
module fcd_seq_tracker
    import flash_cmd_pkg::*;
#(
    parameter int                  CMD_ADDR_W = 15,
    parameter logic [CMD_ADDR_W-1:0] UNLOCK_A = 15'h5555,
    parameter logic [CMD_ADDR_W-1:0] UNLOCK_B = 15'h2AAA
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CMD_ADDR_W-1:0] cmd_addr,
    input  logic [7:0]            cmd_byte,
    output cmd_vec_t              raw_hit
);
    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] ERASE_SET  = 8'h80;
    localparam logic [7:0] SEL_CHIP   = 8'h10;
    localparam logic [7:0] SEL_SECTOR = 8'h30;

    seq_state_e state, state_nxt;
    logic at_a, at_b;

    assign at_a = (cmd_addr == UNLOCK_A);
    assign at_b = (cmd_addr == UNLOCK_B);

    // Next-state and hit decode for the current write.
    always_comb begin
        state_nxt = state;
        raw_hit   = '0;
        if (wr_en) begin
            state_nxt = SQ_IDLE;
            case (state)
                SQ_IDLE:
                    if (at_a && cmd_byte == KEY_FIRST) state_nxt = SQ_UNL1;
                SQ_UNL1:
                    if (at_b && cmd_byte == KEY_SECOND) state_nxt = SQ_UNL2;
                SQ_UNL2:
                    if (at_a) begin
                        if (cmd_byte == ERASE_SET) state_nxt = SQ_ERS_SETUP;
                        else raw_hit = short_code_hit(cmd_byte);
                    end
                SQ_ERS_SETUP:
                    if (at_a && cmd_byte == KEY_FIRST) state_nxt = SQ_ERS_UNL1;
                SQ_ERS_UNL1:
                    if (at_b && cmd_byte == KEY_SECOND) state_nxt = SQ_ERS_UNL2;
                SQ_ERS_UNL2: begin
                    if (at_a && cmd_byte == SEL_CHIP) raw_hit[C_CHIP_ERASE] = 1'b1;
                    else if (cmd_byte == SEL_SECTOR) raw_hit[C_SECT_ERASE] = 1'b1;
                end
                default: state_nxt = SQ_IDLE;
            endcase
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nxt;
    end
endmodule

// File: rtl/fcd_accept_filter.sv
// Masks decoded commands by the operation controller's state.
// Priority: suspended, then program running, then erase running, then idle.
// Purely combinational; assumes the state inputs are synchronous to clk.
module fcd_accept_filter
    import flash_cmd_pkg::*;
(
    input  logic     busy_pgm,
    input  logic     busy_erase,
    input  logic     suspended,
    input  cmd_vec_t raw_hit,
    output cmd_vec_t accepted
);
    localparam cmd_vec_t ONE = cmd_vec_t'(1);
    localparam cmd_vec_t MASK_SUSP = (ONE << C_RD_ARRAY) | (ONE << C_RD_STATUS)
                                   | (ONE << C_ABORT)    | (ONE << C_RESUME);
    localparam cmd_vec_t MASK_PGM  = (ONE << C_RD_STATUS);
    localparam cmd_vec_t MASK_ERS  = (ONE << C_RD_STATUS) | (ONE << C_SUSPEND);
    localparam cmd_vec_t MASK_IDLE = ~((ONE << C_SUSPEND) | (ONE << C_RESUME));

    cmd_vec_t allow;

    // Select the allowed set for the current operation state.
    always_comb begin
        if (suspended)       allow = MASK_SUSP;
        else if (busy_pgm)   allow = MASK_PGM;
        else if (busy_erase) allow = MASK_ERS;
        else                 allow = MASK_IDLE;
    end

    for (genvar i = 0; i < NUM_CMDS; i++) begin : g_gate
        assign accepted[i] = raw_hit[i] & allow[i];
    end
endmodule

// File: rtl/fcd_read_mode.sv
// Holds the read-path selector, updated by accepted commands.
// Assumes at most one accepted command per cycle.
module fcd_read_mode
    import flash_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_vec_t accepted,
    output rd_mode_e mode
);
    logic to_status;

    assign to_status = accepted[C_RD_STATUS] | accepted[C_PROGRAM]
                     | accepted[C_CHIP_ERASE] | accepted[C_SECT_ERASE];

    // Read-path selector register.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mode <= RM_ARRAY;
        else if (accepted[C_RD_ARRAY]) mode <= RM_ARRAY;
        else if (accepted[C_RD_ID])  mode <= RM_IDENT;
        else if (to_status)          mode <= RM_STATUS;
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder: tracks unlock sequences, filters them by
// operation state, registers one-cycle command pulses and the read selector.
// Assumes wr_en is high for exactly one cycle per bus write.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int CMD_ADDR_W = 15,
    parameter int SECT_W     = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [7:0]          cmd_byte,
    input  logic                busy_pgm,
    input  logic                busy_erase,
    input  logic                suspended,
    output logic [NUM_CMDS-1:0] cmd_pulse,
    output logic [ADDR_W-1:0]   erase_addr,
    output logic [1:0]          read_mode
);
    localparam int SECT_LSB = ADDR_W - SECT_W;

    cmd_vec_t raw_hit, accepted;
    rd_mode_e mode;

    fcd_seq_tracker #(
        .CMD_ADDR_W(CMD_ADDR_W),
        .UNLOCK_A  (CMD_ADDR_W'(15'h5555)),
        .UNLOCK_B  (CMD_ADDR_W'(15'h2AAA))
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .cmd_addr(wr_addr[CMD_ADDR_W-1:0]),
        .cmd_byte(cmd_byte),
        .raw_hit (raw_hit)
    );

    fcd_accept_filter u_filt (
        .busy_pgm  (busy_pgm),
        .busy_erase(busy_erase),
        .suspended (suspended),
        .raw_hit   (raw_hit),
        .accepted  (accepted)
    );

    fcd_read_mode u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .accepted(accepted),
        .mode    (mode)
    );

    assign read_mode = mode;

    // Register the pulses and capture the sector erase address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_pulse  <= '0;
            erase_addr <= '0;
        end else begin
            cmd_pulse <= accepted;
            if (accepted[C_SECT_ERASE]) erase_addr <= wr_addr;
        end
    end

    logic [SECT_W-1:0] unused_sector_view;
    assign unused_sector_view = erase_addr[SECT_LSB +: SECT_W];
endmodule

// File: rtl/fcd_checker.sv
// Temporal checks for the flash command decoder, bound to its top.
module fcd_checker
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                busy_pgm,
    input logic                busy_erase,
    input logic                suspended,
    input logic [NUM_CMDS-1:0] cmd_pulse,
    input logic [ADDR_W-1:0]   erase_addr,
    input logic [1:0]          read_mode
);
    localparam cmd_vec_t ONE = cmd_vec_t'(1);
    localparam cmd_vec_t NOT_SUSP_OK = ~((ONE << C_RD_ARRAY) | (ONE << C_RD_STATUS)
                                       | (ONE << C_ABORT) | (ONE << C_RESUME));
    localparam cmd_vec_t NOT_PGM_OK  = ~(ONE << C_RD_STATUS);

    // R2
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_pulse));

    // R2
    pulse_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse != '0) |=> (cmd_pulse == '0));

    // R12
    no_write_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (cmd_pulse == '0));

    // R9
    suspend_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && suspended) |=> ((cmd_pulse & NOT_SUSP_OK) == '0));

    // R7
    program_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy_pgm && !suspended) |=> ((cmd_pulse & NOT_PGM_OK) == '0));

    // R8
    erase_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy_erase && !busy_pgm && !suspended)
        |=> ((cmd_pulse & ~((ONE << C_RD_STATUS) | (ONE << C_SUSPEND))) == '0));

    // R11
    status_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_pulse[C_RD_STATUS] || cmd_pulse[C_PROGRAM]) |-> (read_mode == 2'd2));

    // R3
    sector_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse[C_SECT_ERASE] |-> (erase_addr == $past(wr_addr)));
endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .busy_pgm  (busy_pgm),
    .busy_erase(busy_erase),
    .suspended (suspended),
    .cmd_pulse (cmd_pulse),
    .erase_addr(erase_addr),
    .read_mode (read_mode)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  cmd_byte = '0;
    logic        busy_pgm = 1'b0, busy_erase = 1'b0, suspended = 1'b0;
    logic [10:0] cmd_pulse;
    logic [19:0] erase_addr;
    logic [1:0]  read_mode;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_mode = 0;
    logic [19:0] exp_eaddr = '0;

    always #2 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .cmd_byte(cmd_byte), .busy_pgm(busy_pgm), .busy_erase(busy_erase),
        .suspended(suspended), .cmd_pulse(cmd_pulse), .erase_addr(erase_addr),
        .read_mode(read_mode)
    );

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Third-cycle code for each pulse bit; erase bits use the sixth-cycle selector.
    function automatic logic [7:0] code_of(input int idx);
        case (idx)
            0: return 8'hF0;  1: return 8'h90;  2: return 8'hA0;
            3: return 8'h10;  4: return 8'h30;  5: return 8'hB0;
            6: return 8'hD0;  7: return 8'h70;  8: return 8'h50;
            9: return 8'hC0;  default: return 8'hE0;
        endcase
    endfunction

    // Acceptance per R7..R10.
    function automatic bit allowed(input int idx, input bit pg, input bit er, input bit su);
        if (su) return (idx == 0 || idx == 7 || idx == 10 || idx == 6);
        if (pg) return (idx == 7);
        if (er) return (idx == 7 || idx == 5);
        return (idx != 5 && idx != 6);
    endfunction

    function automatic int mode_after(input int idx, input int cur);
        if (idx == 0) return 0;
        if (idx == 1) return 1;
        if (idx == 7 || idx == 2 || idx == 3 || idx == 4) return 2;
        return cur;
    endfunction

    task automatic bus_wr(input logic [19:0] a, input logic [7:0] d, input bit strobe = 1'b1);
        @(negedge clk);
        wr_en = strobe; wr_addr = a; cmd_byte = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 20'($urandom); cmd_byte = 8'($urandom);
    endtask

    function automatic logic [19:0] ca(input logic [14:0] low);
        return {5'($urandom), low};
    endfunction

    task automatic set_state(input bit pg, input bit er, input bit su);
        @(negedge clk);
        busy_pgm = pg; busy_erase = er; suspended = su;
    endtask

    // Issue a full sequence for command idx and check pulse, mode and sector address.
    task automatic run_cmd(input int idx, input string req);
        logic [19:0] last;
        bit ok;
        bus_wr(ca(15'h5555), 8'hAA);
        bus_wr(ca(15'h2AAA), 8'h55);
        if (idx == 3 || idx == 4) begin
            bus_wr(ca(15'h5555), 8'h80);
            bus_wr(ca(15'h5555), 8'hAA);
            bus_wr(ca(15'h2AAA), 8'h55);
            last = (idx == 3) ? ca(15'h5555) : 20'($urandom);
        end else begin
            last = ca(15'h5555);
        end
        bus_wr(last, code_of(idx));
        ok = allowed(idx, busy_pgm, busy_erase, suspended);
        chk(req, int'(cmd_pulse), ok ? (1 << idx) : 0);
        if (ok) exp_mode = mode_after(idx, exp_mode);
        if (ok && idx == 4) exp_eaddr = last;
        chk("R11 read mode", int'(read_mode), exp_mode);
        chk("R3 erase address", int'(erase_addr), int'(exp_eaddr));
        @(negedge clk);
        chk("R2 pulse lasts one cycle", int'(cmd_pulse), 0);
    endtask

    // Break an erase sequence after k good writes; expect no pulse and a clean tracker.
    task automatic broken_seq(input int k);
        logic [19:0] good_a [6];
        logic [7:0]  good_d [6];
        good_a = '{ca(15'h5555), ca(15'h2AAA), ca(15'h5555), ca(15'h5555), ca(15'h2AAA), ca(15'h5555)};
        good_d = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
        for (int i = 0; i < k; i++) bus_wr(good_a[i], good_d[i]);
        bus_wr(20'h01234, 8'h00);
        chk("R5 broken sequence gives no pulse", int'(cmd_pulse), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 pulses after reset", int'(cmd_pulse), 0);
        chk("R1 read mode after reset", int'(read_mode), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pulses idle after release", int'(cmd_pulse), 0);

        // Directed corner cases.
        set_state(0, 0, 0);
        run_cmd(1, "R2 read ID when idle");
        run_cmd(4, "R3 sector erase with random address");
        run_cmd(3, "R3 chip erase");
        run_cmd(5, "R10 suspend dropped when idle");
        run_cmd(6, "R10 resume dropped when idle");
        set_state(0, 1, 1);
        run_cmd(9, "R9 sleep ignored while suspended");
        run_cmd(6, "R9 resume accepted while suspended");
        set_state(1, 0, 0);
        run_cmd(8, "R7 clear status dropped while programming");
        run_cmd(7, "R7 read status accepted while programming");
        set_state(0, 1, 0);
        run_cmd(5, "R8 suspend accepted while erasing");
        set_state(0, 0, 0);
        run_cmd(7, "R4 read status with random high address bits");

        // R12: a full read-array sequence with the strobe low changes nothing.
        bus_wr(20'h05555, 8'hAA, 1'b0);
        bus_wr(20'h02AAA, 8'h55, 1'b0);
        bus_wr(20'h05555, 8'hF0, 1'b0);
        chk("R12 unstrobed sequence no pulse", int'(cmd_pulse), 0);
        chk("R12 unstrobed sequence keeps mode", int'(read_mode), exp_mode);

        // R6: unlisted code.
        bus_wr(20'h05555, 8'hAA);
        bus_wr(20'h02AAA, 8'h55);
        bus_wr(20'h05555, 8'h33);
        chk("R6 unknown code gives no pulse", int'(cmd_pulse), 0);
        run_cmd(0, "R6 tracker recovers after unknown code");

        // R5: break at every position of the erase sequence.
        for (int k = 0; k < 6; k++) begin
            broken_seq(k);
            run_cmd(7, "R5 next sequence after break");
        end

        // Constrained random mix.
        for (int n = 0; n < 400; n++) begin
            int st;
            int idx;
            st = int'($urandom % 5);
            case (st)
                0: set_state(0, 0, 0);
                1: set_state(1, 0, 0);
                2: set_state(0, 1, 0);
                3: set_state(0, 1, 1);
                default: set_state(1'($urandom), 1'($urandom), 1);
            endcase
            if ($urandom % 8 == 0) begin
                broken_seq(int'($urandom % 6));
            end else begin
                idx = int'($urandom % 11);
                run_cmd(idx, "R2/R7/R8/R9/R10 random command");
            end
        end

        finish_run();
    end
endmodule